// File: doc/BRIEF.md
# Path REI-P G1 byte generator

This block produces the path status (G1) byte for an outbound STS-3c payload envelope. It fills the remote error indication nibble of that byte. The receive side supplies one strobe per incoming SPE, which carries two bytes: the BIP-8 that was computed locally and the B3 byte that was received. The block counts the bit positions where these two bytes disagree and latches the result. The next transmit G1 strobe then uses that latched result.

The upper nibble of G1 comes from one of three sources:
- the count of errored bits, from 0 to 8;
- a single flag that is 1 when any bit was errored;
- a nibble written by software.

The lower nibble always comes from the software G1 value register. A path AIS enable forces the whole byte to all ones.

A small register port holds three registers: the transmit control byte, the G1 value byte and a mode byte. The mode byte selects between count format and flag format.

Top module: `path_rei_gen`

## Requirements
- R1: In count format (mode register bit 0 = 0, hardware insertion), G1[7:4] equals the number of bit positions, from 0 to 8, in which the computed BIP-8 and the received B3 differ for the latched SPE.
- R2: In flag format (mode register bit 0 = 1, hardware insertion), G1[7:4] is 0001 when the latched SPE had at least one differing bit and 0000 otherwise.
- R3: The insertion type is control bits 6:5. The value 01 selects software insertion. The values 00, 10 and 11 select hardware insertion.
- R4: In software insertion, G1[7:4] equals G1 value register bits 7:4. This includes values above 8, which are sent unchanged.
- R5: When AIS is off, G1[3:0] equals G1 value register bits 3:0 in every insertion mode.
- R6: When control bit 0 (AIS enable) is 1, the output G1 byte is 8'hFF.
- R7: The error result is latched on the receive strobe and used by the next transmit strobe. When the receive and transmit strobes occur in the same cycle, the transmit uses the previously latched result.
- R8: tx_g1_o and a one-cycle tx_g1_vld_o pulse appear on the clock after a transmit strobe. tx_g1_o holds its value between strobes.
- R9: The registers are at address 0 (control, all 8 bits), address 1 (G1 value, all 8 bits) and address 2 (mode, bit 0 only, other bits read 0). Address 3 reads 0, and writes to it change nothing.
- R10: Reset clears all registers, the latched result and tx_g1_o to zero, so the first transmitted G1 byte is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_spe_stb_i | input | 1 | One pulse per received SPE |
| rx_bip_calc_i | input | 8 | Locally computed BIP-8 |
| rx_b3_i | input | 8 | Received B3 byte |
| tx_g1_stb_i | input | 1 | Request to build an outgoing G1 byte |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| tx_g1_o | output | 8 | Outgoing G1 byte |
| tx_g1_vld_o | output | 1 | tx_g1_o updated this cycle |

## Verification
Suppose the latched error count or the mode selection is wrong inside the block. The next G1 byte, which appears one cycle after the transmit strobe, then shows a wrong upper nibble. The bench compares every such byte against a model of the latched count and the register contents. A register that does not store or clear correctly shows up at once on the combinational read port, and it also shows up in the next G1 byte. A bad latch ordering is exposed by strobing receive and transmit in the same cycle.

// File: rtl/path_rei_pkg.sv
package path_rei_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    INS_HW0 = 2'b00,
    INS_SW  = 2'b01,
    INS_HW2 = 2'b10,
    INS_HW3 = 2'b11
  } rei_ins_e;

  typedef struct packed {
    logic       f2_type;
    rei_ins_e   rei_type;
    logic [1:0] rdi_type;
    logic       c2_type;
    logic       c2_auto;
    logic       ais_en;
  } tx_ctrl_t;

  function automatic logic [CNT_W-1:0] ones_cnt(input logic [BYTE_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < BYTE_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/rei_err_latch.sv
module rei_err_latch
  import path_rei_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] calc_i,
  input  logic [BYTE_W-1:0] rcvd_i,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (stb_i) cnt_q <= ones_cnt(calc_i ^ rcvd_i);
  end

  assign err_cnt_o = cnt_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BYTE_W));
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(cnt_q));
endmodule

// File: rtl/rei_regs.sv
module rei_regs
  import path_rei_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output tx_ctrl_t          ctrl_o,
  output logic [BYTE_W-1:0] g1val_o,
  output logic              flag_mode_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_G1   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);

  tx_ctrl_t          ctrl_q;
  logic [BYTE_W-1:0] g1_q;
  logic              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      g1_q   <= '0;
      mode_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q <= tx_ctrl_t'(wdata_i);
        A_G1:    g1_q   <= wdata_i;
        A_MODE:  mode_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_G1:    rdata_o = g1_q;
      A_MODE:  rdata_o = {{(BYTE_W-1){1'b0}}, mode_q};
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign g1val_o     = g1_q;
  assign flag_mode_o = mode_q;

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(3)) |=> ($stable(ctrl_q) && $stable(g1_q) && $stable(mode_q)));
endmodule

// File: rtl/g1_build.sv
module g1_build
  import path_rei_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  tx_ctrl_t          ctrl_i,
  input  logic [BYTE_W-1:0] g1val_i,
  input  logic              flag_mode_i,
  input  logic [CNT_W-1:0]  err_cnt_i,
  output logic [BYTE_W-1:0] g1_o,
  output logic              vld_o
);
  logic [NIB_W-1:0]  hw_nib;
  logic [NIB_W-1:0]  hi_nib;
  logic [BYTE_W-1:0] g1_d, g1_q;
  logic              vld_q;

  always_comb begin
    hw_nib = flag_mode_i ? NIB_W'(err_cnt_i != '0) : NIB_W'(err_cnt_i);
    hi_nib = (ctrl_i.rei_type == INS_SW) ? g1val_i[BYTE_W-1:NIB_W] : hw_nib;
    g1_d   = ctrl_i.ais_en ? {BYTE_W{1'b1}} : {hi_nib, g1val_i[NIB_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g1_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= stb_i;
      if (stb_i) g1_q <= g1_d;
    end
  end

  assign g1_o  = g1_q;
  assign vld_o = vld_q;

  p_ais_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && ctrl_i.ais_en) |=> g1_q == {BYTE_W{1'b1}});
  p_sw_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !ctrl_i.ais_en && ctrl_i.rei_type == INS_SW) |=> g1_q == $past(g1val_i));
  p_low_nib_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !ctrl_i.ais_en) |=> g1_q[NIB_W-1:0] == $past(g1val_i[NIB_W-1:0]));
  p_flag_fmt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !ctrl_i.ais_en && ctrl_i.rei_type != INS_SW && flag_mode_i)
    |=> g1_q[BYTE_W-1:NIB_W+1] == '0);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> ($stable(g1_q) && !vld_q));
  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> vld_q);
endmodule

// File: rtl/path_rei_gen.sv
module path_rei_gen
  import path_rei_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_spe_stb_i,
  input  logic [7:0]        rx_bip_calc_i,
  input  logic [7:0]        rx_b3_i,
  input  logic              tx_g1_stb_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [7:0]        tx_g1_o,
  output logic              tx_g1_vld_o
);
  tx_ctrl_t          ctrl;
  logic [BYTE_W-1:0] g1val;
  logic              flag_mode;
  logic [CNT_W-1:0]  err_cnt;

  rei_err_latch u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (rx_spe_stb_i),
    .calc_i    (rx_bip_calc_i),
    .rcvd_i    (rx_b3_i),
    .err_cnt_o (err_cnt)
  );

  rei_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .ctrl_o      (ctrl),
    .g1val_o     (g1val),
    .flag_mode_o (flag_mode)
  );

  g1_build u_g1 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (tx_g1_stb_i),
    .ctrl_i      (ctrl),
    .g1val_i     (g1val),
    .flag_mode_i (flag_mode),
    .err_cnt_i   (err_cnt),
    .g1_o        (tx_g1_o),
    .vld_o       (tx_g1_vld_o)
  );
endmodule

// File: tb/path_rei_gen_tb.sv
`timescale 1ns/1ps
module path_rei_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_stb = 1'b0, tx_stb = 1'b0, wr = 1'b0;
  logic [7:0] calc = '0, b3 = '0, wdata = '0;
  logic [1:0] addr = '0;
  logic [7:0] rdata, g1;
  logic       g1_vld;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model
  logic [7:0] m_ctrl = '0, m_g1 = '0;
  logic       m_flag = 1'b0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  path_rei_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_spe_stb_i(rx_stb), .rx_bip_calc_i(calc), .rx_b3_i(b3),
    .tx_g1_stb_i(tx_stb),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_g1_o(g1), .tx_g1_vld_o(g1_vld)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_g1();
    logic [3:0] hi;
    if (m_ctrl[0]) return 8'hFF;
    if (m_ctrl[6:5] == 2'b01) hi = m_g1[7:4];
    else if (m_flag)          hi = {3'b0, m_cnt != 0};
    else                      hi = 4'(m_cnt);
    return {hi, m_g1[3:0]};
  endfunction

  function automatic int diff_bits(input logic [7:0] a, input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(a[i] ^ b[i]);
    return n;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
    case (a)
      2'd0: m_ctrl = d;
      2'd1: m_g1 = d;
      2'd2: m_flag = d[0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(posedge clk); #1;
    addr = a;
    #2;
    chk(tag, rdata, exp);
  endtask

  task automatic rx_spe(input logic [7:0] c, input logic [7:0] r);
    @(posedge clk); #1;
    rx_stb = 1'b1; calc = c; b3 = r;
    @(posedge clk); #1;
    rx_stb = 1'b0;
    m_cnt = diff_bits(c, r);
  endtask

  task automatic tx_g1(input string tag);
    @(posedge clk); #1;
    tx_stb = 1'b1;
    exp_q.push_back(model_g1());
    tag_q.push_back(tag);
    @(posedge clk); #1;
    tx_stb = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // R7: receive and transmit strobe in the same cycle
  task automatic rx_tx_same(input logic [7:0] c, input logic [7:0] r, input string tag);
    @(posedge clk); #1;
    rx_stb = 1'b1; calc = c; b3 = r; tx_stb = 1'b1;
    exp_q.push_back(model_g1());
    tag_q.push_back(tag);
    @(posedge clk); #1;
    rx_stb = 1'b0; tx_stb = 1'b0;
    m_cnt = diff_bits(c, r);
    repeat (2) @(posedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && g1_vld) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: unexpected valid pulse, actual %02h expected none", g1);
      end else begin
        chk(tag_q.pop_front(), g1, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    rd_chk("R10 ctrl reset", 2'd0, 8'h00);
    rd_chk("R10 g1val reset", 2'd1, 8'h00);
    rd_chk("R10 mode reset", 2'd2, 8'h00);
    chk("R10 g1 out reset", g1, 8'h00);
    tx_g1("R10 first g1");

    // R1 count format
    wr_reg(2'd1, 8'h5A);
    rx_spe(8'hFF, 8'h00); tx_g1("R1 count 8");
    rx_spe(8'h12, 8'h12); tx_g1("R1 count 0");
    rx_spe(8'h01, 8'h07); tx_g1("R1 count 2");
    rx_spe(8'h80, 8'h00); tx_g1("R1 count 1");

    // R2 flag format
    wr_reg(2'd2, 8'h01);
    rx_spe(8'hF0, 8'h0F); tx_g1("R2 flag set");
    rx_spe(8'h33, 8'h33); tx_g1("R2 flag clear");

    // R4 software insertion, R3 field decode
    wr_reg(2'd0, 8'h20);
    wr_reg(2'd1, 8'hC3); tx_g1("R4 sw nibble above 8");
    wr_reg(2'd1, 8'h06); tx_g1("R4 sw nibble 0");
    rx_spe(8'hAA, 8'h55);
    wr_reg(2'd1, 8'h37); tx_g1("R4 sw ignores error count");
    wr_reg(2'd0, 8'h40); tx_g1("R3 type 10 hardware flag");
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h60); tx_g1("R3 type 11 hardware count");
    wr_reg(2'd0, 8'h98); tx_g1("R5 low nibble with other ctrl bits");

    // R6 AIS
    wr_reg(2'd0, 8'h21); tx_g1("R6 ais with sw mode");
    wr_reg(2'd0, 8'h01); tx_g1("R6 ais hw mode");
    wr_reg(2'd0, 8'h00);

    // R7 ordering
    rx_spe(8'h00, 8'h00);
    rx_tx_same(8'h0F, 8'h00, "R7 same-cycle uses old count");
    tx_g1("R7 next tx uses new count");

    // R8 hold between strobes
    held = g1;
    repeat (5) @(posedge clk);
    #2;
    chk("R8 output held", g1, held);
    chk("R8 valid low", {7'b0, g1_vld}, 8'h00);

    // R9 register map
    wr_reg(2'd0, 8'hB5);
    rd_chk("R9 ctrl readback", 2'd0, 8'hB5);
    wr_reg(2'd2, 8'hFE);
    rd_chk("R9 mode readback bit0 only", 2'd2, 8'h00);
    wr_reg(2'd2, 8'hFF);
    rd_chk("R9 mode readback", 2'd2, 8'h01);
    wr_reg(2'd3, 8'hFF);
    rd_chk("R9 unmapped reads zero", 2'd3, 8'h00);
    rd_chk("R9 ctrl unchanged", 2'd0, 8'hB5);
    rd_chk("R9 g1val unchanged", 2'd1, m_g1);
    rd_chk("R9 mode unchanged", 2'd2, 8'h01);

    repeat (4) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8: missing valid pulses, actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule